// File: doc/BRIEF.md
# Block Address Translation Matcher

This block translates an effective address through a small set of block translation pairs. Each pair covers a naturally aligned region whose size is set per pair, from 128 KiB to 256 MiB. A pair has two 32-bit words. The tag word holds the region base, a size field and two privilege-qualified enable bits. The real word holds the physical base and a protection field. Two separate arrays are kept: one searched by instruction fetches and one searched by loads and stores.

Software loads the words through a single register-write port by giving the side, the word half, the pair index and the data. A lookup presents an address, a user/supervisor flag and an access kind. The block then reports, one cycle later, one of three results: a completed translation with its permissions, a permission denial by the first qualifying pair, or a miss. All lookup logic is combinational between the request and a single result register.

Top module: `blk_xlate`

## Requirements
- R1: A request with kind 2 (fetch) searches only the instruction-side pairs. Kinds 0 (read), 1 (write) and 3 (treated as read) search only the data-side pairs. The write side is chosen with cfgInstr=1 for instruction and 0 for data.
- R2: The size mask is tag bits [12:2] placed at address bits [27:17]. A pair matches when address bits [31:28] equal tag bits [31:28], and address bits [27:17] with the masked positions cleared equal tag bits [27:17]. A tag with a set bit inside its own masked positions never matches.
- R3: Tag bit 1 enables the pair for supervisor requests (reqUser=0). Tag bit 0 enables it for user requests (reqUser=1). A matching pair that is not enabled for the request's privilege is skipped.
- R4: Real-word bits [1:0] are the protection code. Code 0 gives no rights, code 2 gives read, write and execute, and codes 1 and 3 give read and execute. A read needs read, a write needs write and a fetch needs execute.
- R5: On a hit, the physical address is formed from four parts ORed together: real bits [31:28], the address bits at the masked positions of [27:17], real bits [27:17], and address bits [16:12]. Bits [11:0] of the result are zero.
- R6: Pairs are examined from index 0 upward. The lowest-index pair that both matches and is enabled decides the result, even if a later pair would allow the access.
- R7: If the deciding pair lacks the needed right, rspHit=0 and rspDenied=1. The rspRead/rspWrite/rspExec outputs show that pair's rights and rspAddr is zero.
- R8: A request sampled at a clock edge produces rspValid=1 with its result after that edge. A cycle with no request produces rspValid=0.
- R9: A pair write takes effect for requests sampled at later edges. A request in the same cycle as the write sees the old contents.
- R10: Reset clears all pairs and the result register, so lookups after reset miss.
- R11: When no pair decides, the result has rspHit=0 and rspDenied=0, with the address and rights all zero. The same holds whenever rspValid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Pair word write strobe |
| cfgInstr | input | 1 | Write targets instruction side (1) or data side (0) |
| cfgLower | input | 1 | Write targets real word (1) or tag word (0) |
| cfgIdx | input | IDX_W | Pair index for the write |
| cfgData | input | 32 | Word written |
| reqValid | input | 1 | Lookup request |
| reqAddr | input | 32 | Effective address |
| reqUser | input | 1 | 1 = user request, 0 = supervisor |
| reqKind | input | 2 | 0 read, 1 write, 2 fetch, 3 read |
| rspValid | output | 1 | Result present |
| rspHit | output | 1 | Translation completed |
| rspDenied | output | 1 | Deciding pair refused the access |
| rspAddr | output | 32 | Physical page address |
| rspRead | output | 1 | Deciding pair grants read |
| rspWrite | output | 1 | Deciding pair grants write |
| rspExec | output | 1 | Deciding pair grants execute |

## Verification
The hardest case is an earlier pair that matches and is enabled but refuses the access, while a later pair covers the same address and would allow it. Random tables rarely line up that way. A directed sequence therefore loads two overlapping data pairs with different protection codes and different privilege enables. It then shows that a supervisor request is denied by the first pair, and that a user request skips that pair and is translated by the second. The random phase keeps region bases in a few 256 MiB windows and draws most addresses from inside existing tags. This produces frequent overlaps, mask-dependent matches and bad tags whose masked bits are set.

// File: rtl/blk_xlate_pkg.sv
package blk_xlate_pkg;
  localparam int unsigned ADDR_W  = 32;
  localparam int unsigned HI_LSB  = 28;
  localparam int unsigned LO_LSB  = 17;
  localparam int unsigned LO_W    = HI_LSB - LO_LSB;
  localparam int unsigned BL_LSB  = 2;
  localparam int unsigned PG_LSB  = 12;
  localparam int unsigned SUP_BIT = 1;
  localparam int unsigned USR_BIT = 0;

  typedef enum logic [1:0] {
    KIND_READ  = 2'd0,
    KIND_WRITE = 2'd1,
    KIND_FETCH = 2'd2,
    KIND_ALT   = 2'd3
  } accKind_e;

  typedef struct packed {
    logic wrTag;
    logic wrReal;
    logic wrInstr;
    logic capture;
  } ctrlStrobe_t;

  // rights packed as {read, write, exec}
  function automatic logic [2:0] rightsOf(input logic [1:0] code);
    case (code)
      2'd0:    rightsOf = 3'b000;
      2'd2:    rightsOf = 3'b111;
      default: rightsOf = 3'b101;
    endcase
  endfunction
endpackage

// File: rtl/blk_xlate_ctrl.sv
module blk_xlate_ctrl
  import blk_xlate_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWrEn,
  input  logic        cfgInstr,
  input  logic        cfgLower,
  input  logic        reqValid,
  output ctrlStrobe_t stb,
  output logic        rspValid
);
  always_comb begin
    stb.wrTag   = cfgWrEn & ~cfgLower;
    stb.wrReal  = cfgWrEn & cfgLower;
    stb.wrInstr = cfgInstr;
    stb.capture = reqValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rspValid <= 1'b0;
    else       rspValid <= reqValid;
  end
endmodule

// File: rtl/blk_xlate_entry.sv
module blk_xlate_entry
  import blk_xlate_pkg::*;
(
  input  logic [ADDR_W-1:0] tagWord,
  input  logic [ADDR_W-1:0] realWord,
  input  logic [ADDR_W-1:0] addr,
  input  logic              user,
  output logic              sel,
  output logic [ADDR_W-1:0] physAddr,
  output logic [2:0]        rights
);
  logic [LO_W-1:0] sizeMask;
  logic            hiEq;
  logic            loEq;
  logic            enabled;
  logic            unusedBits;

  assign sizeMask = tagWord[BL_LSB +: LO_W];
  assign hiEq     = addr[ADDR_W-1:HI_LSB] == tagWord[ADDR_W-1:HI_LSB];
  assign loEq     = (addr[LO_LSB +: LO_W] & ~sizeMask) == tagWord[LO_LSB +: LO_W];
  assign enabled  = user ? tagWord[USR_BIT] : tagWord[SUP_BIT];
  assign sel      = hiEq & loEq & enabled;

  assign physAddr = {realWord[ADDR_W-1:HI_LSB],
                     (addr[LO_LSB +: LO_W] & sizeMask) | realWord[LO_LSB +: LO_W],
                     addr[LO_LSB-1:PG_LSB],
                     {PG_LSB{1'b0}}};
  assign rights   = rightsOf(realWord[1:0]);

  assign unusedBits = ^{tagWord[LO_LSB-1:BL_LSB+LO_W], realWord[LO_LSB-1:2],
                        addr[PG_LSB-1:0]};
endmodule

// File: rtl/blk_xlate_dpath.sv
module blk_xlate_dpath
  import blk_xlate_pkg::*;
#(
  parameter int NUM_PAIRS = 4,
  parameter int IDX_W     = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       stb,
  input  logic [IDX_W-1:0]  cfgIdx,
  input  logic [ADDR_W-1:0] cfgData,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqUser,
  input  logic [1:0]        reqKind,
  output logic              rspHit,
  output logic              rspDenied,
  output logic [ADDR_W-1:0] rspAddr,
  output logic              rspRead,
  output logic              rspWrite,
  output logic              rspExec
);
  logic [ADDR_W-1:0] tagI  [NUM_PAIRS];
  logic [ADDR_W-1:0] realI [NUM_PAIRS];
  logic [ADDR_W-1:0] tagD  [NUM_PAIRS];
  logic [ADDR_W-1:0] realD [NUM_PAIRS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < NUM_PAIRS; k++) begin
        tagI[k]  <= '0;
        realI[k] <= '0;
        tagD[k]  <= '0;
        realD[k] <= '0;
      end
    end else begin
      for (int k = 0; k < NUM_PAIRS; k++) begin
        if (cfgIdx == IDX_W'(k)) begin
          if (stb.wrTag  &&  stb.wrInstr) tagI[k]  <= cfgData;
          if (stb.wrReal &&  stb.wrInstr) realI[k] <= cfgData;
          if (stb.wrTag  && !stb.wrInstr) tagD[k]  <= cfgData;
          if (stb.wrReal && !stb.wrInstr) realD[k] <= cfgData;
        end
      end
    end
  end

  accKind_e          kind;
  logic              isFetch;
  logic [NUM_PAIRS-1:0] sel;
  logic [ADDR_W-1:0] physArr  [NUM_PAIRS];
  logic [2:0]        rightArr [NUM_PAIRS];

  assign kind    = accKind_e'(reqKind);
  assign isFetch = kind == KIND_FETCH;

  for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
    blk_xlate_entry uEnt (
      .tagWord  (isFetch ? tagI[g]  : tagD[g]),
      .realWord (isFetch ? realI[g] : realD[g]),
      .addr     (reqAddr),
      .user     (reqUser),
      .sel      (sel[g]),
      .physAddr (physArr[g]),
      .rights   (rightArr[g])
    );
  end

  logic              found;
  logic [ADDR_W-1:0] winAddr;
  logic [2:0]        winRights;
  logic              allowed;

  always_comb begin
    found     = 1'b0;
    winAddr   = '0;
    winRights = '0;
    for (int k = NUM_PAIRS - 1; k >= 0; k--) begin
      if (sel[k]) begin
        found     = 1'b1;
        winAddr   = physArr[k];
        winRights = rightArr[k];
      end
    end
    case (kind)
      KIND_FETCH: allowed = winRights[0];
      KIND_WRITE: allowed = winRights[1];
      default:    allowed = winRights[2];
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspHit    <= 1'b0;
      rspDenied <= 1'b0;
      rspAddr   <= '0;
      {rspRead, rspWrite, rspExec} <= 3'b000;
    end else if (stb.capture) begin
      rspHit    <= found & allowed;
      rspDenied <= found & ~allowed;
      rspAddr   <= (found & allowed) ? winAddr : '0;
      {rspRead, rspWrite, rspExec} <= found ? winRights : 3'b000;
    end else begin
      rspHit    <= 1'b0;
      rspDenied <= 1'b0;
      rspAddr   <= '0;
      {rspRead, rspWrite, rspExec} <= 3'b000;
    end
  end
endmodule

// File: rtl/blk_xlate.sv
module blk_xlate
  import blk_xlate_pkg::*;
#(
  parameter  int NUM_PAIRS = 4,
  localparam int IDX_W     = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic              cfgInstr,
  input  logic              cfgLower,
  input  logic [IDX_W-1:0]  cfgIdx,
  input  logic [31:0]       cfgData,
  input  logic              reqValid,
  input  logic [31:0]       reqAddr,
  input  logic              reqUser,
  input  logic [1:0]        reqKind,
  output logic              rspValid,
  output logic              rspHit,
  output logic              rspDenied,
  output logic [31:0]       rspAddr,
  output logic              rspRead,
  output logic              rspWrite,
  output logic              rspExec
);
  ctrlStrobe_t stb;

  blk_xlate_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWrEn  (cfgWrEn),
    .cfgInstr (cfgInstr),
    .cfgLower (cfgLower),
    .reqValid (reqValid),
    .stb      (stb),
    .rspValid (rspValid)
  );

  blk_xlate_dpath #(.NUM_PAIRS(NUM_PAIRS), .IDX_W(IDX_W)) uDpath (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .cfgIdx    (cfgIdx),
    .cfgData   (cfgData),
    .reqAddr   (reqAddr),
    .reqUser   (reqUser),
    .reqKind   (reqKind),
    .rspHit    (rspHit),
    .rspDenied (rspDenied),
    .rspAddr   (rspAddr),
    .rspRead   (rspRead),
    .rspWrite  (rspWrite),
    .rspExec   (rspExec)
  );
endmodule

// File: rtl/blk_xlate_chk.sv
module blk_xlate_chk (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic [31:0] reqAddr,
  input logic [1:0]  reqKind,
  input logic        rspValid,
  input logic        rspHit,
  input logic        rspDenied,
  input logic [31:0] rspAddr,
  input logic        rspRead,
  input logic        rspWrite,
  input logic        rspExec
);
  p_resp_follows_r8: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  p_resp_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);

  p_quiet_when_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> (!rspHit && !rspDenied && rspAddr == 32'd0
                   && !rspRead && !rspWrite && !rspExec));

  p_hit_deny_excl_r7: assert property (@(posedge clk) disable iff (!rstN)
    rspHit |-> !rspDenied);

  p_hit_has_right_r4: assert property (@(posedge clk) disable iff (!rstN)
    rspHit |-> (($past(reqKind) == 2'd2) ? rspExec :
                ($past(reqKind) == 2'd1) ? rspWrite : rspRead));

  p_deny_lacks_right_r7: assert property (@(posedge clk) disable iff (!rstN)
    rspDenied |-> (($past(reqKind) == 2'd2) ? !rspExec :
                   ($past(reqKind) == 2'd1) ? !rspWrite : !rspRead));

  p_deny_no_addr_r7: assert property (@(posedge clk) disable iff (!rstN)
    rspDenied |-> rspAddr == 32'd0);

  p_page_bits_pass_r5: assert property (@(posedge clk) disable iff (!rstN)
    rspHit |-> (rspAddr[16:12] == $past(reqAddr[16:12]) && rspAddr[11:0] == 12'd0));

  p_write_implies_all_r4: assert property (@(posedge clk) disable iff (!rstN)
    rspWrite |-> (rspRead && rspExec));
endmodule

bind blk_xlate blk_xlate_chk uChk (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .reqAddr   (reqAddr),
  .reqKind   (reqKind),
  .rspValid  (rspValid),
  .rspHit    (rspHit),
  .rspDenied (rspDenied),
  .rspAddr   (rspAddr),
  .rspRead   (rspRead),
  .rspWrite  (rspWrite),
  .rspExec   (rspExec)
);

// File: tb/sim_blk_xlate.sv
`timescale 1ns/1ps
module sim_blk_xlate;
  localparam int NP = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic        cfgInstr = 1'b0;
  logic        cfgLower = 1'b0;
  logic [1:0]  cfgIdx = '0;
  logic [31:0] cfgData = '0;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic        reqUser = 1'b0;
  logic [1:0]  reqKind = '0;
  logic        rspValid, rspHit, rspDenied, rspRead, rspWrite, rspExec;
  logic [31:0] rspAddr;

  always #10 clk = ~clk;

  blk_xlate #(.NUM_PAIRS(NP)) u0 (.*);

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  // model tables: [side][index], side 1 = instruction
  logic [31:0] mTag  [2][NP];
  logic [31:0] mReal [2][NP];

  // result vector {valid, hit, denied, r, w, x, addr}
  function automatic logic [37:0] expect_of(input logic [31:0] a, input logic usr,
                                            input logic [1:0] kd);
    int s;
    s = (kd == 2'd2) ? 1 : 0;
    for (int i = 0; i < NP; i++) begin
      logic [31:0] u, l, bl;
      logic ok, r, w, x;
      u  = mTag[s][i];
      l  = mReal[s][i];
      bl = (u & 32'h0000_1FFC) << 15;
      if ((a & 32'hF000_0000) == (u & 32'hF000_0000) &&
          ((a & 32'h0FFE_0000) & ~bl) == (u & 32'h0FFE_0000) &&
          (usr ? u[0] : u[1])) begin
        r  = (l[1:0] != 2'd0);
        x  = r;
        w  = (l[1:0] == 2'd2);
        ok = (kd == 2'd2) ? x : (kd == 2'd1) ? w : r;
        return {1'b1, ok, !ok, r, w, x,
                ok ? ((l & 32'hF000_0000) | (a & 32'h0FFE_0000 & bl) |
                      (l & 32'h0FFE_0000) | (a & 32'h0001_F000)) : 32'd0};
      end
    end
    return {1'b1, 37'd0};
  endfunction

  function automatic logic [37:0] observed();
    return {rspValid, rspHit, rspDenied, rspRead, rspWrite, rspExec, rspAddr};
  endfunction

  task automatic compare(input logic [37:0] exp, input string req);
    logic [37:0] got;
    got = observed();
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got v%0b h%0b d%0b rwx%0b%0b%0b a=%08h, expected v%0b h%0b d%0b rwx%0b%0b%0b a=%08h",
               req, got[37], got[36], got[35], got[34], got[33], got[32], got[31:0],
               exp[37], exp[36], exp[35], exp[34], exp[33], exp[32], exp[31:0]);
    end
  endtask

  task automatic cfg_write(input logic side, input logic lower, input int idx,
                           input logic [31:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgInstr = side; cfgLower = lower; cfgIdx = 2'(idx); cfgData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
    if (lower) mReal[side][idx] = d;
    else       mTag[side][idx]  = d;
  endtask

  task automatic set_pair(input logic side, input int idx, input logic [31:0] t,
                          input logic [31:0] r);
    cfg_write(side, 1'b0, idx, t);
    cfg_write(side, 1'b1, idx, r);
  endtask

  task automatic lookup(input logic [31:0] a, input logic usr, input logic [1:0] kd,
                        input string req);
    logic [37:0] exp;
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a; reqUser = usr; reqKind = kd;
    exp = expect_of(a, usr, kd);
    @(negedge clk);
    reqValid = 1'b0;
    compare(exp, req);
  endtask

  function automatic logic [31:0] rand_tag();
    logic [10:0] blm, lo;
    blm = 11'((32'd1 << $urandom_range(0, 11)) - 1);
    lo  = 11'($urandom) & ~blm;
    if ($urandom_range(0, 9) == 0) lo = lo | 11'($urandom);
    return {4'($urandom_range(0, 3)), lo, 4'd0, blm, 2'($urandom)};
  endfunction

  initial begin : watchdog
    #(20 * 200000);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd20240611));
    for (int s = 0; s < 2; s++)
      for (int i = 0; i < NP; i++) begin mTag[s][i] = '0; mReal[s][i] = '0; end

    repeat (3) @(negedge clk);
    // R10: reset state of the outputs
    compare({1'b0, 37'd0}, "R10 reset outputs");
    rstN = 1'b1;
    @(negedge clk);
    // R10: empty tables miss; R11 miss result
    lookup(32'h0000_0000, 1'b0, 2'd0, "R10 empty table supervisor read");
    lookup(32'h1234_5678, 1'b1, 2'd2, "R11 empty table user fetch");

    // R5: 128 KiB supervisor-only data pair, rwx
    set_pair(1'b0, 0, 32'h1000_0002, 32'h8000_0002);
    lookup(32'h1001_5ABC, 1'b0, 2'd0, "R5 small block supervisor read");
    lookup(32'h1001_5ABC, 1'b0, 2'd1, "R4 small block supervisor write");
    lookup(32'h1002_0000, 1'b0, 2'd0, "R2 just past small block");
    // R3: user request skips supervisor-only pair
    lookup(32'h1001_5ABC, 1'b1, 2'd0, "R3 user skips supervisor-only");
    // R1: fetch does not see the data pair
    lookup(32'h1001_5ABC, 1'b0, 2'd2, "R1 fetch ignores data side");

    // R2/R5: 256 MiB read-only pair, both privileges
    set_pair(1'b0, 1, 32'h2000_1FFF, 32'h4000_0001);
    lookup(32'h2ABC_D123, 1'b1, 2'd0, "R5 large block address merge");
    lookup(32'h2ABC_D123, 1'b0, 2'd1, "R7 write to read-only block denied");
    lookup(32'h2ABC_D123, 1'b0, 2'd2, "R1 fetch of data-only region misses");

    // R6: overlapping pairs, first is supervisor-only no-access
    set_pair(1'b0, 2, 32'h3000_0002, 32'h5000_0000);
    set_pair(1'b0, 3, 32'h3000_0003, 32'h6000_0002);
    lookup(32'h3000_4000, 1'b0, 2'd0, "R6 first pair decides with denial");
    lookup(32'h3000_4000, 1'b1, 2'd1, "R6 user skips to later pair");

    // R1: instruction side pair at the same address
    set_pair(1'b1, 0, 32'h1000_0002, 32'h9000_0001);
    lookup(32'h1001_5ABC, 1'b0, 2'd2, "R1 fetch uses instruction side");
    lookup(32'h1001_5ABC, 1'b0, 2'd3, "R1 kind 3 uses data side");
    lookup(32'h1001_5ABC, 1'b0, 2'd1, "R4 write to read-exec fetch pair via data side");

    // R2: tag with a bit set inside its own mask never matches
    set_pair(1'b1, 1, 32'h7002_0006, 32'hA000_0002);
    lookup(32'h7002_0000, 1'b0, 2'd2, "R2 bad tag never matches");
    lookup(32'h7000_0000, 1'b0, 2'd2, "R2 bad tag never matches low");

    // R9: write and lookup in the same cycle sees old contents
    begin
      logic [37:0] exp;
      @(negedge clk);
      cfgWrEn = 1'b1; cfgInstr = 1'b0; cfgLower = 1'b1; cfgIdx = 2'd1; cfgData = 32'h4000_0002;
      reqValid = 1'b1; reqAddr = 32'h2000_0000; reqUser = 1'b0; reqKind = 2'd1;
      exp = expect_of(32'h2000_0000, 1'b0, 2'd1);
      @(negedge clk);
      cfgWrEn = 1'b0; reqValid = 1'b0;
      compare(exp, "R9 same-cycle lookup sees old pair");
      mReal[0][1] = 32'h4000_0002;
      lookup(32'h2000_0000, 1'b0, 2'd1, "R9 next lookup sees new pair");
    end

    // R8: idle cycle clears the result
    @(negedge clk);
    compare({1'b0, 37'd0}, "R8 idle cycle no result");

    // random phase: R2 R3 R4 R5 R6 R7 R1 against the model
    for (int it = 0; it < 800; it++) begin
      if ($urandom_range(0, 7) == 0) begin
        logic sd;
        int ix;
        sd = 1'($urandom);
        ix = $urandom_range(0, NP - 1);
        set_pair(sd, ix, rand_tag(), $urandom);
      end else begin
        logic [31:0] a, b;
        logic [1:0] kd;
        int ix;
        kd = 2'($urandom);
        ix = $urandom_range(0, NP - 1);
        b  = mTag[(kd == 2'd2) ? 1 : 0][ix];
        if ($urandom_range(0, 3) == 0)
          a = {4'($urandom_range(0, 3)), 28'($urandom)};
        else
          a = (b & 32'hFFFE_0000) ^ ($urandom & ((b & 32'h0000_1FFC) << 15))
              | ($urandom & 32'h0001_FFFF);
        if ($urandom_range(0, 5) == 0) begin
          @(negedge clk);
          compare({1'b0, 37'd0}, "R8 random idle gap");
        end
        lookup(a, 1'($urandom), kd, "R6 random lookup");
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule